// File: doc/BRIEF.md
# Page Descriptor Bank with Access Tracking

This block holds the page descriptor registers of a memory-management unit, arranged as several sets of sixteen 16-bit descriptors. Software reads and writes the descriptors over a word-addressed register bus with two byte lanes. It can write a whole word, the even (low) byte alone, or the odd (high) byte alone. Descriptors are addressed by a flat index, set number times 16 plus page number. With the default of three sets the valid indices are 0 to 47.

The address translation path reports each memory access it completes through a one-cycle report: the descriptor index, whether the access was a write, and whether translation aborted it. The block keeps two hardware-owned status bits in every descriptor. The accessed bit is bit 7 and the written bit is bit 6. An access that is not aborted sets the accessed bit. A write access also sets the written bit. Any software write to a descriptor clears both bits, whichever byte lanes it enables. The other 14 bits are plain storage for software.

Top module: `pdr_track_bank`

## Requirements
- R1: After reset every descriptor reads as 0x0000.
- R2: A word write (`bus_be` = 2'b11) stores `bus_wdata` with bit 7 and bit 6 forced to 0.
- R3: An even-byte write (`bus_be` = 2'b01) replaces bits 7:0 from `bus_wdata[7:0]` with bits 7 and 6 forced to 0, and it keeps bits 15:8.
- R4: An odd-byte write (`bus_be` = 2'b10) replaces bits 15:8 from `bus_wdata[15:8]`, keeps bits 5:0, and clears bits 7 and 6.
- R5: A report with `trk_valid`=1 and `trk_abort`=0 sets bit 7 (accessed) of the indexed descriptor from the next cycle on.
- R6: Such a report with `trk_write`=1 also sets bit 6 (written). With `trk_write`=0, bit 6 keeps its value.
- R7: A report with `trk_abort`=1 leaves the indexed descriptor unchanged.
- R8: When a bus write and a successful report name the same descriptor in one cycle, the bus write result is stored and bits 7 and 6 end up 0.
- R9: An index of 48 or above reads as 0. A bus write or a report with such an index changes no descriptor.
- R10: `bus_rdata` shows the descriptor at `bus_addr` combinationally, including the update from the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Descriptor index for bus read and write |
| bus_we | input | 1 | Bus write strobe |
| bus_be | input | 2 | Byte lanes: bit 0 even byte, bit 1 odd byte |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Descriptor at `bus_addr` |
| trk_valid | input | 1 | Access report valid |
| trk_index | input | 6 | Descriptor index of the reported access |
| trk_write | input | 1 | Reported access was a write |
| trk_abort | input | 1 | Reported access was aborted |

## Verification
The bench targets an odd-byte write to a descriptor whose status bits are set. A design that clears the status bits only when the low lane is enabled would leave bit 7 and bit 6 set in that case. It also sends aborted read and write reports to clean descriptors. A design that ignored the abort flag would show a status bit set afterwards. It drives a bus write and a successful report to the same index in one cycle; a design with the wrong priority would keep bit 7 set. It also uses indices past the last set, where a design that wrapped the index would corrupt a low descriptor. A long random stream, compared against the reference model every cycle, covers mixed lanes and back-to-back reports.

// File: rtl/pdr_track_bank.sv
module pdr_track_bank #(
  parameter int NSETS = 3,
  parameter int PAGES = 16,
  parameter int ABIT  = 7,
  parameter int WBIT  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [$clog2(NSETS*PAGES)-1:0] bus_addr,
  input  logic        bus_we,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        trk_valid,
  input  logic [$clog2(NSETS*PAGES)-1:0] trk_index,
  input  logic        trk_write,
  input  logic        trk_abort
);
  localparam int NREG = NSETS * PAGES;
  localparam int IW = $clog2(NREG);
  localparam logic [IW:0] LIMIT = NREG[IW:0];

  logic [15:0] pdr [NREG];
  logic [15:0] merged;

  wire bus_ok = ({1'b0, bus_addr} < LIMIT);
  wire trk_ok = ({1'b0, trk_index} < LIMIT);
  wire wr_hit = bus_we && bus_ok;
  wire tk_hit = trk_valid && !trk_abort && trk_ok;

  assign bus_rdata = bus_ok ? pdr[bus_addr] : 16'h0000;

  always_comb begin
    merged = bus_rdata;
    if (bus_be[0]) merged[7:0] = bus_wdata[7:0];
    if (bus_be[1]) merged[15:8] = bus_wdata[15:8];
    merged[ABIT] = 1'b0;
    merged[WBIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) pdr[i] <= '0;
    end else begin
      if (tk_hit) begin
        pdr[trk_index][ABIT] <= 1'b1;
        if (trk_write) pdr[trk_index][WBIT] <= 1'b1;
      end
      if (wr_hit) pdr[bus_addr] <= merged;
    end
  end

  a_r4_odd_byte_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_ok && bus_be == 2'b10) |=>
      (pdr[$past(bus_addr)][ABIT] == 1'b0 && pdr[$past(bus_addr)][WBIT] == 1'b0));

  a_r5_access_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && !trk_abort && trk_ok && !(bus_we && bus_addr == trk_index)) |=>
      pdr[$past(trk_index)][ABIT]);

  a_r6_write_sets_w: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && !trk_abort && trk_write && trk_ok && !(bus_we && bus_addr == trk_index)) |=>
      pdr[$past(trk_index)][WBIT]);

  a_r7_abort_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && trk_abort && trk_ok && !(bus_we && bus_addr == trk_index)) |=>
      (pdr[$past(trk_index)] == $past(pdr[trk_index])));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && !trk_abort && bus_we && bus_ok && bus_addr == trk_index) |=>
      (pdr[$past(bus_addr)][ABIT] == 1'b0 && pdr[$past(bus_addr)][WBIT] == 1'b0));
endmodule

// File: tb/tb_pdr_track_bank.sv
module tb_pdr_track_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        trk_valid = 1'b0;
  logic [5:0]  trk_index = '0;
  logic        trk_write = 1'b0;
  logic        trk_abort = 1'b0;

  int checks = 0;
  int fails = 0;
  int model [64];

  always #4 clk = ~clk;

  pdr_track_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trk_valid(trk_valid), .trk_index(trk_index), .trk_write(trk_write),
    .trk_abort(trk_abort)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input int addr, input logic [1:0] be,
                     input int wd, input logic tv, input int tidx,
                     input logic tw, input logic ta, input string tag);
    int nv;
    @(negedge clk);
    bus_we = we; bus_addr = addr[5:0]; bus_be = be; bus_wdata = wd[15:0];
    trk_valid = tv; trk_index = tidx[5:0]; trk_write = tw; trk_abort = ta;
    @(posedge clk);
    if (tv && !ta && tidx < 48) model[tidx] = model[tidx] | (tw ? 'hC0 : 'h80);
    if (we && addr < 48) begin
      nv = model[addr];
      if (be[0]) nv = (nv & 'hFF00) | (wd & 'h00FF);
      if (be[1]) nv = (nv & 'h00FF) | (wd & 'hFF00);
      model[addr] = nv & 'hFF3F;
    end
    #2;
    chk(tag, int'(bus_rdata), (addr < 48) ? model[addr] : 0);
  endtask

  task automatic rd(input int addr, input string tag);
    cyc(1'b0, addr, 2'b00, 0, 1'b0, 0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 64; i++) rd(i, "R1 reset");

    cyc(1'b0, 5, 2'b00, 0, 1'b1, 5, 1'b0, 1'b0, "R5 read access sets A");
    cyc(1'b0, 5, 2'b00, 0, 1'b1, 5, 1'b1, 1'b0, "R6 write access sets W");
    cyc(1'b1, 5, 2'b11, 'hFFFF, 1'b0, 0, 1'b0, 1'b0, "R2 word write");
    cyc(1'b0, 5, 2'b00, 0, 1'b1, 5, 1'b1, 1'b0, "R6 set again");
    cyc(1'b1, 5, 2'b01, 'h12AA, 1'b0, 0, 1'b0, 1'b0, "R3 even byte write");
    cyc(1'b0, 5, 2'b00, 0, 1'b1, 5, 1'b1, 1'b0, "R6 set again");
    cyc(1'b1, 5, 2'b10, 'h34FF, 1'b0, 0, 1'b0, 1'b0, "R4 odd byte write clears");
    cyc(1'b0, 5, 2'b00, 0, 1'b1, 5, 1'b0, 1'b0, "R6 read keeps W clear");
    cyc(1'b0, 20, 2'b00, 0, 1'b1, 20, 1'b1, 1'b1, "R7 aborted write");
    cyc(1'b0, 21, 2'b00, 0, 1'b1, 21, 1'b0, 1'b1, "R7 aborted read");
    rd(20, "R7 still clean");
    cyc(1'b0, 30, 2'b00, 0, 1'b1, 30, 1'b1, 1'b0, "R5 set before conflict");
    cyc(1'b1, 30, 2'b01, 'h00C3, 1'b1, 30, 1'b1, 1'b0, "R8 write wins");
    cyc(1'b1, 47, 2'b11, 'h8001, 1'b1, 47, 1'b1, 1'b0, "R8 last index");
    cyc(1'b1, 50, 2'b11, 'hFFFF, 1'b1, 50, 1'b1, 1'b0, "R9 out of range");
    rd(2, "R9 no wrap to low index");
    rd(18, "R9 no wrap to low index");
    rd(63, "R9 top index reads zero");
    cyc(1'b0, 47, 2'b00, 0, 1'b1, 47, 1'b0, 1'b0, "R10 same-cycle read after set");

    for (int n = 0; n < 3000; n++) begin
      int a = $urandom_range(0, 63);
      int t = ($urandom_range(0, 3) == 0) ? a : $urandom_range(0, 63);
      cyc(1'($urandom_range(0, 2) == 0), a, 2'($urandom_range(0, 3)),
          $urandom_range(0, 65535), 1'($urandom_range(0, 1)), t,
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
          "R10 random vs model");
    end
    for (int i = 0; i < 64; i++) rd(i, "R2 final sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule